// File: doc/BRIEF.md
# Bus Breakpoint Comparator Unit

This block watches a CPU's address bus, data bus and read/write strobe and raises a break request when a bus cycle matches the programmed breakpoint. Software sets it up through a small register file. One control register selects one of four operating modes, chooses how a match becomes a break, and sets a page-range flag for each comparator. There are also two compare registers. The first compare register always holds an address. The mode decides whether the second one holds a second address or a data value.

A match turns into a break request in one of two ways. The first way arms a pending flag, and the break fires at the next instruction boundary, which is signalled by an execute-start strobe. The second way is opcode tagging. Each fetched opcode carries a tag bit through a two-entry prefetch queue. The break fires only when a tagged opcode actually starts executing, so data accesses and opcodes that are fetched but flushed never cause a break. The software-interrupt mode always uses tagging. Each request leaves the block as a one-cycle pulse, either on the software-interrupt output or on the background-debug output.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the control register and both compare registers are zero, and neither request output is asserted.
- R2: Register select 0 is the control register: bits 7:6 are the mode, bit 5 is program-only, bit 1 is the range flag of comparator 1 and bit 0 is the range flag of comparator 0. Bits 4:2 and all upper bits read as 0. Select 1 is compare register 0, select 2 is compare register 1, and select 3 reads 0 and ignores writes. Writes are accepted in any cycle and are visible on the read port from the next cycle.
- R3: In mode 00 no bus cycle matches, and no request is issued in the cycle after a cycle spent in mode 00.
- R4: In mode 01, a valid bus cycle whose address equals either compare register matches, whatever the read/write strobe is. This mode always uses tagging whatever bit 5 holds, and its breaks appear on swi_req.
- R5: In mode 10, a match needs three things: the address equals compare register 0, the data bus equals all bits of compare register 1, and bus_rnw equals rw_sel0. Breaks appear on bdm_req.
- R6: In mode 11, a cycle matches if either of two conditions holds: the address equals compare register 0 and bus_rnw equals rw_sel0, or the address equals compare register 1 and bus_rnw equals rw_sel1. Breaks appear on bdm_req.
- R7: When the range flag of comparator 0 is 0, only address bits 15:8 are compared against compare register 0. This applies in every mode.
- R8: The range flag of comparator 1 masks the low byte of the address compare only in modes 01 and 11. The data compare in mode 10 always uses all 16 bits.
- R9: In modes 10 and 11 with bit 5 at 0, a match sets a pending flag. bdm_req pulses in the cycle after the next execute-start strobe, and that strobe clears the flag unless a new match arrives in the same cycle.
- R10: In tagging operation, an opcode fetch is tagged only if it matches, and a match on any other cycle is ignored. A request pulses in the cycle after an execute-start strobe that retires a tagged head entry.
- R11: The tag queue holds 2 entries in first-in, first-out order. A fetch made while the queue is full and nothing retires is dropped. A flush empties the queue, and a fetch or execute-start in the same cycle has no effect.
- R12: Requests are registered one-cycle pulses, and swi_req and bdm_req are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 2 | Register write select |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 2 | Register read select |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_valid | input | 1 | A CPU bus cycle is in progress |
| bus_addr | input | 16 | CPU address bus |
| bus_data | input | 16 | CPU data bus |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| rw_sel0 | input | 1 | Expected direction for comparator 0 |
| rw_sel1 | input | 1 | Expected direction for comparator 1 |
| opc_fetch | input | 1 | This bus cycle fetches an opcode into the queue |
| exec_start | input | 1 | The queue head starts executing (instruction boundary) |
| q_flush | input | 1 | Prefetch queue flush |
| swi_req | output | 1 | Software-interrupt break request pulse |
| bdm_req | output | 1 | Background-debug break request pulse |

## Verification
The bench goes after the cases where a near-miss must not break. It changes only the low address byte while a range flag is clear or set. It gets the data compare right but the direction wrong in mode 10. It sets comparator 1's range flag in mode 10, where that flag must be ignored. A design that masked the wrong register, or honoured the flag in the wrong mode, would break on these cycles or miss them. Tagging is tested with matching data accesses and with tagged opcodes that are flushed before they execute. A design that broke on a match instead of on execution would then fire early or for cycles that are never executed. Queue ordering, fetches that arrive while the queue is full, a flush in the same cycle as execute, and execute arriving together with a fresh match all catch off-by-one shifting or a pending flag that is cleared too eagerly.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_SWI_DUAL = 2'b01,
    MODE_BDM_FULL = 2'b10,
    MODE_BDM_DUAL = 2'b11
  } bk_mode_e;

  typedef struct packed {
    bk_mode_e mode;
    logic     prog_only;
    logic     rng1;
    logic     rng0;
  } bk_ctrl_t;

  localparam int CTRL_W = 8;

  // Pack the control fields into their readable byte image.
  function automatic logic [CTRL_W-1:0] ctrl_image(input bk_ctrl_t c);
    return {c.mode, c.prog_only, 3'b000, c.rng1, c.rng0};
  endfunction

  // Unpack a written byte into the control fields.
  function automatic bk_ctrl_t ctrl_decode(input logic [CTRL_W-1:0] b);
    bk_ctrl_t c;
    c.mode      = bk_mode_e'(b[7:6]);
    c.prog_only = b[5];
    c.rng1      = b[1];
    c.rng0      = b[0];
    return c;
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_waddr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [BUS_W-1:0] reg_rdata,
  output bk_ctrl_t         ctrl,
  output logic [BUS_W-1:0] cmp0,
  output logic [BUS_W-1:0] cmp1
);

  localparam int PAD_W = BUS_W - CTRL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= ctrl_decode('0);
      cmp0 <= '0;
      cmp1 <= '0;
    end else if (reg_we) begin
      case (reg_waddr)
        2'd0:    ctrl <= ctrl_decode(reg_wdata[CTRL_W-1:0]);
        2'd1:    cmp0 <= reg_wdata;
        2'd2:    cmp1 <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_raddr)
      2'd0:    reg_rdata = {{PAD_W{1'b0}}, ctrl_image(ctrl)};
      2'd1:    reg_rdata = cmp0;
      2'd2:    reg_rdata = cmp1;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int PAGE_W = 8
) (
  input  bk_ctrl_t         ctrl,
  input  logic [BUS_W-1:0] cmp0,
  input  logic [BUS_W-1:0] cmp1,
  input  logic             bus_valid,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_rnw,
  input  logic             rw_sel0,
  input  logic             rw_sel1,
  output logic             hit,
  output logic             prog_only
);

  localparam logic [BUS_W-1:0] PAGE_MASK = {{(BUS_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  // Address equality, low page bits excluded unless full is set.
  function automatic logic addr_eq(input logic [BUS_W-1:0] cref,
                                   input logic [BUS_W-1:0] a,
                                   input logic             full);
    logic [BUS_W-1:0] m;
    m = full ? {BUS_W{1'b1}} : PAGE_MASK;
    return ((cref ^ a) & m) == '0;
  endfunction

  logic a0, a1, d1, rw0_ok, rw1_ok, raw;

  assign a0     = addr_eq(cmp0, bus_addr, ctrl.rng0);
  assign a1     = addr_eq(cmp1, bus_addr, ctrl.rng1);
  assign d1     = (bus_data == cmp1);
  assign rw0_ok = (bus_rnw == rw_sel0);
  assign rw1_ok = (bus_rnw == rw_sel1);

  always_comb begin
    case (ctrl.mode)
      MODE_SWI_DUAL: raw = a0 | a1;
      MODE_BDM_FULL: raw = a0 & d1 & rw0_ok;
      MODE_BDM_DUAL: raw = (a0 & rw0_ok) | (a1 & rw1_ok);
      default:       raw = 1'b0;
    endcase
  end

  assign hit       = bus_valid & raw;
  assign prog_only = (ctrl.mode == MODE_SWI_DUAL) | ctrl.prog_only;

endmodule

// File: rtl/bkpt_tagq.sv
module bkpt_tagq #(
  parameter int QDEPTH = 2,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          push_tag,
  input  logic          pop_req,
  output logic          fire,
  output logic [CW-1:0] cnt
);

  logic [QDEPTH-1:0] tags, tags_d;
  logic [CW-1:0]     rem, cnt_d;
  logic              pop, push_ok;

  assign pop     = pop_req && (cnt != '0) && !flush;
  assign rem     = cnt - CW'(pop);
  assign push_ok = push && !flush && (rem < CW'(QDEPTH));
  assign cnt_d   = flush ? '0 : rem + CW'(push_ok);
  assign fire    = pop && tags[0];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    logic up;
    if (i == QDEPTH - 1) begin : g_last
      assign up = 1'b0;
    end else begin : g_mid
      assign up = tags[i+1];
    end
    assign tags_d[i] = (push_ok && rem == CW'(i)) ? push_tag : (pop ? up : tags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags <= '0;
      cnt  <= '0;
    end else begin
      tags <= tags_d;
      cnt  <= cnt_d;
    end
  end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int PAGE_W = 8,
  parameter int QDEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_waddr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             bus_valid,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_rnw,
  input  logic             rw_sel0,
  input  logic             rw_sel1,
  input  logic             opc_fetch,
  input  logic             exec_start,
  input  logic             q_flush,
  output logic             swi_req,
  output logic             bdm_req
);

  localparam int CW = $clog2(QDEPTH + 1);

  bk_ctrl_t         ctrl;
  logic [BUS_W-1:0] cmp0, cmp1;
  logic [1:0]       mode_w;
  logic             hit_w, prog_only_w, tag_fire_w, bdm_mode_w, pend_q, pend_d;
  logic             boundary_fire_w;
  logic [CW-1:0]    q_cnt_w;

  bkpt_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .cmp0(cmp0), .cmp1(cmp1)
  );

  bkpt_match #(.BUS_W(BUS_W), .PAGE_W(PAGE_W)) u_match (
    .ctrl(ctrl), .cmp0(cmp0), .cmp1(cmp1), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_rnw(bus_rnw),
    .rw_sel0(rw_sel0), .rw_sel1(rw_sel1), .hit(hit_w), .prog_only(prog_only_w)
  );

  bkpt_tagq #(.QDEPTH(QDEPTH)) u_tagq (
    .clk(clk), .rst_n(rst_n), .flush(q_flush), .push(opc_fetch),
    .push_tag(hit_w & prog_only_w), .pop_req(exec_start),
    .fire(tag_fire_w), .cnt(q_cnt_w)
  );

  assign mode_w          = ctrl.mode;
  assign bdm_mode_w      = ctrl.mode inside {MODE_BDM_FULL, MODE_BDM_DUAL};
  assign boundary_fire_w = exec_start & pend_q & bdm_mode_w;
  assign pend_d          = (pend_q & ~exec_start) | (hit_w & ~prog_only_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      swi_req <= 1'b0;
      bdm_req <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      swi_req <= tag_fire_w & (ctrl.mode == MODE_SWI_DUAL);
      bdm_req <= (tag_fire_w & bdm_mode_w) | boundary_fire_w;
    end
  end

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int BUS_W  = 16,
  parameter int QDEPTH = 2,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_w,
  input logic             hit_w,
  input logic             prog_only_w,
  input logic             pend_q,
  input logic             exec_start,
  input logic             q_flush,
  input logic [CW-1:0]    q_cnt_w,
  input logic [1:0]       reg_raddr,
  input logic [BUS_W-1:0] reg_rdata,
  input logic             swi_req,
  input logic             bdm_req
);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 2'd0) |-> (reg_rdata[4:2] == 3'b000));

  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 2'b00) |=> (!swi_req && !bdm_req));

  p_swi_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req |-> ($past(mode_w) == 2'b01));

  p_bdm_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bdm_req |-> $past(mode_w[1]));

  p_arm_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !prog_only_w) |=> pend_q);

  p_need_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req || bdm_req) |-> $past(exec_start));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> (q_cnt_w == '0));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt_w <= CW'(QDEPTH));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(swi_req && bdm_req));

endmodule

bind bkpt_unit bkpt_unit_chk #(.BUS_W(BUS_W), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_w(mode_w), .hit_w(hit_w),
  .prog_only_w(prog_only_w), .pend_q(pend_q), .exec_start(exec_start),
  .q_flush(q_flush), .q_cnt_w(q_cnt_w), .reg_raddr(reg_raddr),
  .reg_rdata(reg_rdata), .swi_req(swi_req), .bdm_req(bdm_req)
);

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 0;
  logic [1:0]  reg_waddr = 0, reg_raddr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        bus_valid = 0, bus_rnw = 0, rw_sel0 = 0, rw_sel1 = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic        opc_fetch = 0, exec_start = 0, q_flush = 0;
  logic        swi_req, bdm_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bkpt_unit u_bkpt_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rnw(bus_rnw), .rw_sel0(rw_sel0), .rw_sel1(rw_sel1),
    .opc_fetch(opc_fetch), .exec_start(exec_start), .q_flush(q_flush),
    .swi_req(swi_req), .bdm_req(bdm_req)
  );

  // Reference state
  logic [7:0]  m_ctrl = 0;
  logic [15:0] m_c0 = 0, m_c1 = 0;
  bit          m_pend = 0, m_swi = 0, m_bdm = 0;
  bit          m_q [2] = '{0, 0};
  int          m_cnt = 0;

  function automatic bit page_ok(input logic [15:0] c, input logic [15:0] a, input bit full);
    return (c[15:8] == a[15:8]) && (!full || (c[7:0] == a[7:0]));
  endfunction

  function bit ref_hit();
    bit z0, z1;
    z0 = page_ok(m_c0, bus_addr, m_ctrl[0]);
    z1 = page_ok(m_c1, bus_addr, m_ctrl[1]);
    if (!bus_valid) return 0;
    case (m_ctrl[7:6])
      2'b01:   return z0 || z1;
      2'b10:   return z0 && (bus_data == m_c1) && (bus_rnw == rw_sel0);
      2'b11:   return (z0 && bus_rnw == rw_sel0) || (z1 && bus_rnw == rw_sel1);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: predict, advance, compare requests.
  task automatic step(input string tag);
    bit h, po, n_pend, n_swi, n_bdm;
    bit nq [2];
    int ncnt;
    logic [7:0] n_ctrl;
    logic [15:0] n_c0, n_c1;
    logic [1:0] md;
    md = m_ctrl[7:6];
    h = ref_hit();
    po = (md == 2'b01) || m_ctrl[5];
    n_pend = (m_pend && !exec_start) || (h && !po);
    n_swi = 0;
    n_bdm = exec_start && m_pend && md[1];
    nq = m_q; ncnt = m_cnt;
    if (q_flush) ncnt = 0;
    else begin
      if (exec_start && m_cnt > 0) begin
        if (m_q[0]) begin
          if (md == 2'b01) n_swi = 1;
          if (md[1]) n_bdm = 1;
        end
        nq[0] = m_q[1]; nq[1] = 0; ncnt--;
      end
      if (opc_fetch && ncnt < 2) begin
        nq[ncnt] = h && po; ncnt++;
      end
    end
    n_ctrl = m_ctrl; n_c0 = m_c0; n_c1 = m_c1;
    if (reg_we) begin
      if (reg_waddr == 0) n_ctrl = reg_wdata[7:0] & 8'hE3;
      if (reg_waddr == 1) n_c0 = reg_wdata;
      if (reg_waddr == 2) n_c1 = reg_wdata;
    end
    @(posedge clk); #2;
    m_ctrl = n_ctrl; m_c0 = n_c0; m_c1 = n_c1; m_pend = n_pend;
    m_q = nq; m_cnt = ncnt; m_swi = n_swi; m_bdm = n_bdm;
    chk({tag, " swi_req"}, 16'(swi_req), 16'(m_swi));
    chk({tag, " bdm_req"}, 16'(bdm_req), 16'(m_bdm));
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; bus_valid = 0; opc_fetch = 0; exec_start = 0; q_flush = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    idle(); reg_we = 1; reg_waddr = a; reg_wdata = d;
    step("R2");
    reg_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a);
    logic [15:0] e;
    reg_raddr = a; #1;
    case (a)
      2'd0: e = {8'h00, m_ctrl};
      2'd1: e = m_c0;
      2'd2: e = m_c1;
      default: e = 16'h0000;
    endcase
    chk(tag, reg_rdata, e);
  endtask

  task automatic bus(input logic [15:0] a, input logic [15:0] d, input bit rnw,
                     input bit f, input bit x);
    idle(); bus_valid = 1; bus_addr = a; bus_data = d; bus_rnw = rnw;
    opc_fetch = f; exec_start = x;
  endtask

  task automatic exec_only();
    idle(); exec_start = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hB4C7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", 0); rd_chk("R1 cmp0", 1); rd_chk("R1 cmp1", 2);
    chk("R1 swi_req", 16'(swi_req), 16'h0);
    chk("R1 bdm_req", 16'(bdm_req), 16'h0);

    // R2 readback, reserved bits and select 3
    wr(0, 16'hFFFF); rd_chk("R2 ctrl", 0);
    chk("R2 ctrl image", reg_rdata, 16'h00E3);
    wr(3, 16'h5A5A); rd_chk("R2 sel3", 3);

    // R3 mode off: matching fetch then execute gives nothing
    wr(0, 16'h0003); wr(1, 16'h1234);
    bus(16'h1234, 0, 1, 1, 0); step("R3");
    exec_only(); step("R3");
    chk("R3 quiet", 16'(swi_req | bdm_req), 16'h0);

    // R4 software-interrupt mode, comparator 1, write strobe, bit5 clear
    wr(0, 16'h0043); wr(2, 16'h8800);
    bus(16'h8800, 0, 0, 1, 0); step("R4");
    exec_only(); step("R4");
    chk("R4 swi pulse", 16'(swi_req), 16'h1);
    idle(); step("R12");
    chk("R12 one cycle", 16'(swi_req), 16'h0);

    // R10 data access hit does not tag
    bus(16'h1234, 0, 1, 0, 0); step("R10");
    bus(16'h0100, 0, 1, 1, 0); step("R10");
    exec_only(); step("R10");
    chk("R10 untagged", 16'(swi_req), 16'h0);

    // R7 page match on comparator 0
    wr(0, 16'h0040);
    bus(16'h12AB, 0, 1, 1, 0); step("R7");
    exec_only(); step("R7");
    chk("R7 page hit", 16'(swi_req), 16'h1);

    // R5/R9 full mode, boundary break
    wr(0, 16'h0081); wr(1, 16'h2000); wr(2, 16'hBEEF);
    rw_sel0 = 1;
    bus(16'h2000, 16'hBEEE, 1, 0, 0); step("R5 data miss");
    bus(16'h2000, 16'hBEEF, 0, 0, 0); step("R5 dir miss");
    exec_only(); step("R5");
    chk("R5 no break", 16'(bdm_req), 16'h0);
    bus(16'h2000, 16'hBEEF, 1, 0, 0); step("R9 arm");
    chk("R9 not yet", 16'(bdm_req), 16'h0);
    idle(); step("R9 wait");
    exec_only(); step("R9");
    chk("R9 fires", 16'(bdm_req), 16'h1);

    // R8 range flag 1 ignored in full mode
    wr(0, 16'h0083);
    bus(16'h2000, 16'hBE00, 1, 0, 0); step("R8");
    exec_only(); step("R8");
    chk("R8 full data", 16'(bdm_req), 16'h0);

    // R6/R8 dual-address mode with per-comparator direction, page on cmp1
    wr(0, 16'h00C1); rw_sel1 = 0;
    bus(16'hBE77, 0, 1, 0, 0); step("R6 dir miss");
    bus(16'hBE77, 0, 0, 0, 1); step("R6 hit+exec");
    exec_only(); step("R6");
    chk("R6 break", 16'(bdm_req), 16'h1);

    // R11 tagged queue order, full drop, flush
    wr(0, 16'h00E1);
    bus(16'h2000, 0, 1, 1, 0); step("R11");
    bus(16'h3000, 0, 1, 1, 0); step("R11");
    bus(16'h2000, 0, 1, 1, 0); step("R11 full drop");
    exec_only(); step("R11");
    chk("R11 head tagged", 16'(bdm_req), 16'h1);
    exec_only(); step("R11");
    chk("R11 second untagged", 16'(bdm_req), 16'h0);
    exec_only(); step("R11 empty");
    chk("R11 dropped", 16'(bdm_req), 16'h0);
    bus(16'h2000, 0, 1, 1, 0); step("R11");
    idle(); q_flush = 1; exec_start = 1; step("R11 flush");
    exec_only(); step("R11");
    chk("R11 flushed", 16'(bdm_req), 16'h0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      idle();
      if ($urandom_range(9) == 0) begin
        reg_we = 1; reg_waddr = 2'($urandom_range(3));
        reg_wdata = 16'($urandom);
      end
      bus_valid = ($urandom_range(3) != 0);
      case ($urandom_range(3))
        0: bus_addr = {m_c0[15:8], 8'($urandom)};
        1: bus_addr = m_c0;
        2: bus_addr = $urandom_range(1) ? m_c1 : {m_c1[15:8], 8'($urandom)};
        default: bus_addr = 16'($urandom);
      endcase
      bus_data = $urandom_range(1) ? m_c1 : 16'($urandom);
      bus_rnw = 1'($urandom); rw_sel0 = 1'($urandom); rw_sel1 = 1'($urandom);
      opc_fetch = ($urandom_range(9) < 4);
      exec_start = ($urandom_range(9) < 3);
      q_flush = ($urandom_range(19) == 0);
      step("R12 random");
      if (i % 16 == 0) rd_chk("R2 random", 2'($urandom_range(3)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule